// File: doc/BRIEF.md
# Packed Vector Right-Shift Unit with Insert

This block executes immediate right-shift operations on a packed vector held in a 128-bit word. The vector is either 64 or 128 bits wide and is divided into equal lanes of 8, 16, 32 or 64 bits. Three operations are supported:
- a plain shift of each source lane;
- a shift whose result is added to the matching lane of the old destination;
- an insert, which writes the shifted source bits into the low part of each destination lane and keeps the destination bits above them.

Lane width and shift distance both come from a single 7-bit immediate, split into a 4-bit high part and a 3-bit low part. The position of the leading one in the high part sets the lane width. The full immediate, subtracted from twice the lane width, gives the shift distance. Encodings that are not allowed raise an illegal flag and return the old destination unchanged.

The unit is used as one stage of a vector execute pipe. Operands and decode fields are presented with a valid strobe. The result, the illegal flag and a matching valid come out of a register one cycle later.

Top module: `vsr_unit`

## Requirements
- R1: Lane width is 8 when imm_hi is 4'b0001, 16 for 4'b001x, 32 for 4'b01xx and 64 for 4'b1xxx. imm_hi equal to zero is illegal.
- R2: The shift distance equals 2*lane width minus the 7-bit value {imm_hi, imm_lo}. It therefore lies between 1 and the lane width.
- R3: When wide is 1 the vector is 128 bits; when wide is 0 it is 64 bits. Lane i occupies bits [i*W +: W]. With wide at 0, bits [127:64] of a legal result are zero.
- R4: Opcode 5'h00 is a plain shift. With uns at 1 the shift is logical (zero fill); with uns at 0 it is arithmetic (sign fill). The old destination has no effect.
- R5: Opcode 5'h02 is shift-and-accumulate. Each shifted lane, shifted by the uns rule of R4, is added to the old destination lane modulo 2^W.
- R6: Opcode 5'h08 with uns at 1 is insert. The low W-shift bits of each destination lane take the logically shifted source lane, and the upper shift bits of the destination lane are kept.
- R7: An insert with a shift equal to the lane width returns the destination lane unchanged.
- R8: Opcode 5'h08 with uns at 0 is illegal. In that case illegal is 1 and the result equals dst_vec.
- R9: Any opcode other than 5'h00, 5'h02 or 5'h08 is illegal, and so is a 64-bit lane with wide at 0. Both return dst_vec with illegal at 1.
- R10: result, illegal and out_valid are registered one cycle after a cycle with in_valid high, and out_valid is low otherwise. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Old destination vector |
| imm_hi | input | 4 | High immediate part (lane width and shift) |
| imm_lo | input | 3 | Low immediate part (shift) |
| opcode | input | 5 | Operation select |
| uns | input | 1 | Unsigned flag |
| wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result vector |
| illegal | output | 1 | Illegal-encoding flag |

## Verification
Two behaviours can meet in the same operation: the full-width shift and the partial-lane merge of insert. With the shift equal to the lane width, the merge mask must fall to nothing, so the destination lane passes through instead of receiving a shifted value. The second meeting point is the illegal check against the normal datapath. An insert opcode with uns clear, or a 64-bit lane with wide clear, must win over the computed lanes. Directed cases drive each of these for every lane width, and random operations mix them with ordinary shifts. Every output is compared against a lane-by-lane bench model.

// File: rtl/vsr_pkg.sv
// Shared types for the vector shift-right unit.
// Assumes opcodes arrive as 5-bit values; only three are legal.
package vsr_pkg;
    localparam int VEC_W  = 128;
    localparam int HALF_W = 64;
    localparam int SH_W   = 7;

    typedef enum logic [1:0] {
        M_SHIFT  = 2'd0,
        M_ACCUM  = 2'd1,
        M_INSERT = 2'd2
    } vsr_mode_e;

    localparam logic [4:0] OPC_SHIFT  = 5'h00;
    localparam logic [4:0] OPC_ACCUM  = 5'h02;
    localparam logic [4:0] OPC_INSERT = 5'h08;
endpackage

// File: rtl/vsr_decode.sv
// Decodes the immediate into a lane-size code and a shift distance,
// maps the opcode to an operation mode and flags illegal encodings.
// Assumes pure combinational use; no state.
module vsr_decode
    import vsr_pkg::*;
(
    input  logic [3:0]      imm_hi,
    input  logic [2:0]      imm_lo,
    input  logic [4:0]      opcode,
    input  logic            uns,
    input  logic            wide,
    output logic [1:0]      size,
    output logic [SH_W-1:0] shamt,
    output vsr_mode_e       mode,
    output logic            bad
);
    logic [7:0] twice_w;
    logic       bad_op;

    // Lane-size code from the leading one of the high immediate.
    always_comb begin
        casez (imm_hi)
            4'b1???: size = 2'd3;
            4'b01??: size = 2'd2;
            4'b001?: size = 2'd1;
            default: size = 2'd0;
        endcase
    end

    // Shift distance: twice the lane width minus the whole immediate.
    always_comb begin
        twice_w = 8'd16 << size;
        shamt   = SH_W'(twice_w - {1'b0, imm_hi, imm_lo});
    end

    // Opcode to mode, with the unsigned qualifier on insert.
    always_comb begin
        mode   = M_SHIFT;
        bad_op = 1'b0;
        case (opcode)
            OPC_SHIFT:  mode = M_SHIFT;
            OPC_ACCUM:  mode = M_ACCUM;
            OPC_INSERT: begin
                mode   = M_INSERT;
                bad_op = !uns;
            end
            default:    bad_op = 1'b1;
        endcase
    end

    // Combine all illegal conditions.
    assign bad = bad_op || (imm_hi == 4'd0) || (size == 2'd3 && !wide);
endmodule

// File: rtl/vsr_lane.sv
// One lane of the shift datapath, LW bits wide.
// Assumes shamt is in 1..LW; a shift of LW on insert leaves dst intact.
module vsr_lane
    import vsr_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW-1:0]   src,
    input  logic [LW-1:0]   dst,
    input  logic [SH_W-1:0] shamt,
    input  vsr_mode_e       mode,
    input  logic            uns,
    output logic [LW-1:0]   res
);
    localparam logic [SH_W-1:0] LW_SH = SH_W'(LW);

    logic [LW-1:0] shifted;
    logic [LW-1:0] low_mask;

    // Shift with zero fill or sign fill; insert always uses zero fill.
    always_comb begin
        if (uns || mode == M_INSERT)
            shifted = src >> shamt;
        else
            shifted = LW'($signed(src) >>> shamt);
    end

    // Mask of the destination bits that insert overwrites.
    always_comb begin
        if (shamt >= LW_SH)
            low_mask = '0;
        else
            low_mask = {LW{1'b1}} >> shamt;
    end

    // Final lane value per mode.
    always_comb begin
        case (mode)
            M_ACCUM:  res = dst + shifted;
            M_INSERT: res = (dst & ~low_mask) | (shifted & low_mask);
            default:  res = shifted;
        endcase
    end
endmodule

// File: rtl/vsr_unit.sv
// Top of the vector shift-right unit. Builds one lane array per lane
// width, selects by the decoded size, applies the 64-bit vector clear
// and the illegal passthrough, then registers the outcome.
// Assumes inputs are stable around the clock edge where in_valid is high.
module vsr_unit
    import vsr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [127:0] src_vec,
    input  logic [127:0] dst_vec,
    input  logic [3:0]   imm_hi,
    input  logic [2:0]   imm_lo,
    input  logic [4:0]   opcode,
    input  logic         uns,
    input  logic         wide,
    output logic         out_valid,
    output logic [127:0] result,
    output logic         illegal
);
    logic [1:0]       dec_size;
    logic [SH_W-1:0]  dec_shamt;
    vsr_mode_e        dec_mode;
    logic             dec_bad;
    logic [VEC_W-1:0] cand [4];
    logic [VEC_W-1:0] next_res;

    vsr_decode u_dec (
        .imm_hi (imm_hi),
        .imm_lo (imm_lo),
        .opcode (opcode),
        .uns    (uns),
        .wide   (wide),
        .size   (dec_size),
        .shamt  (dec_shamt),
        .mode   (dec_mode),
        .bad    (dec_bad)
    );

    // One lane array for each of the four lane widths.
    for (genvar sz = 0; sz < 4; sz++) begin : g_size
        localparam int LW = 8 << sz;
        localparam int NL = VEC_W / LW;
        for (genvar ln = 0; ln < NL; ln++) begin : g_lane
            vsr_lane #(.LW(LW)) u_lane (
                .src   (src_vec[ln*LW +: LW]),
                .dst   (dst_vec[ln*LW +: LW]),
                .shamt (dec_shamt),
                .mode  (dec_mode),
                .uns   (uns),
                .res   (cand[sz][ln*LW +: LW])
            );
        end
    end

    // Pick the lane array, clear the upper half for 64-bit vectors,
    // or return the old destination on an illegal encoding.
    always_comb begin
        next_res = cand[dec_size];
        if (!wide)
            next_res[VEC_W-1:HALF_W] = '0;
        if (dec_bad)
            next_res = dst_vec;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= next_res;
                illegal <= dec_bad;
            end
        end
    end

    p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_keep_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && illegal |-> result == $past(dst_vec));
    p_insert_signed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opcode == OPC_INSERT && !uns |=> illegal);
    p_zero_imm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && imm_hi == 4'd0 |=> illegal);
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !illegal && !$past(wide) |-> result[127:64] == 64'd0);
    p_shift_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dec_bad |-> dec_shamt >= 7'd1 && dec_shamt <= (7'd8 << dec_size));
endmodule

// File: tb/sim_vsr_unit.sv
module sim_vsr_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_vec = '0, dst_vec = '0;
    logic [3:0]   imm_hi = 4'd1;
    logic [2:0]   imm_lo = 3'd0;
    logic [4:0]   opcode = 5'd0;
    logic         uns = 1'b0, wide = 1'b0;
    logic         out_valid, illegal;
    logic [127:0] result;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vsr_unit u0 (.clk, .rst_n, .in_valid, .src_vec, .dst_vec, .imm_hi, .imm_lo,
                 .opcode, .uns, .wide, .out_valid, .result, .illegal);

    function automatic logic [63:0] lmask(int lw);
        return (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
    endfunction

    function automatic int lane_w(logic [3:0] h);
        if (h[3]) return 64;
        if (h[2]) return 32;
        if (h[1]) return 16;
        return 8;
    endfunction

    function automatic bit is_bad(logic [3:0] h, logic [4:0] op, logic u, logic q);
        if (h == 4'd0) return 1;
        if (op != 5'h00 && op != 5'h02 && op != 5'h08) return 1;
        if (op == 5'h08 && !u) return 1;
        if (lane_w(h) == 64 && !q) return 1;
        return 0;
    endfunction

    function automatic logic [127:0] model(logic [127:0] s, logic [127:0] d,
            logic [3:0] h, logic [2:0] l, logic [4:0] op, logic u, logic q);
        int lw, sh, n;
        logic [63:0] m, a, b, r, keep;
        logic [127:0] out;
        if (is_bad(h, op, u, q)) return d;
        lw = lane_w(h);
        sh = 2 * lw - int'({h, l});
        m = lmask(lw);
        n = (q ? 128 : 64) / lw;
        out = '0;
        for (int i = 0; i < n; i++) begin
            a = 64'(s >> (i * lw)) & m;
            b = 64'(d >> (i * lw)) & m;
            if (op == 5'h08) begin
                keep = (sh == lw) ? 64'd0 : (m >> sh);
                r = (b & ~keep) | ((a >> sh) & keep);
            end else begin
                if (u) r = a >> sh;
                else begin
                    if (a[lw-1]) a = a | ~m;
                    r = 64'($signed(a) >>> sh) & m;
                end
                if (op == 5'h02) r = (r + b) & m;
            end
            out = out | (128'(r & m) << (i * lw));
        end
        return out;
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run(string tag, logic [127:0] s, logic [127:0] d, logic [3:0] h,
                       logic [2:0] l, logic [4:0] op, logic u, logic q);
        @(negedge clk);
        src_vec = s; dst_vec = d; imm_hi = h; imm_lo = l;
        opcode = op; uns = u; wide = q; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid (R10)"}, 128'(out_valid), 128'd1);
        check({tag, " illegal"}, 128'(illegal), 128'(is_bad(h, op, u, q)));
        check({tag, " result"}, result, model(s, d, h, l, op, u, q));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        logic [127:0] s, d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R10 reset valid", 128'(out_valid), 128'd0);
        check("R10 reset result", result, 128'd0);
        check("R10 reset illegal", 128'(illegal), 128'd0);
        rst_n = 1'b1;
        s = rnd128(); d = rnd128();
        run("R1 zero imm_hi", s, d, 4'd0, 3'd5, 5'h00, 1'b1, 1'b1);
        for (int sz = 0; sz < 4; sz++) begin
            // shift equal to lane width: immediate equals lane width
            logic [6:0] full = 7'(8 << sz);
            run("R7 insert full shift", rnd128(), rnd128(), full[6:3], full[2:0], 5'h08, 1'b1, 1'b1);
            run("R2 shift of one", rnd128(), rnd128(), 4'hF >> (3 - sz), 3'h7, 5'h00, 1'b0, 1'b1);
            run("R6 insert", rnd128(), rnd128(), 4'(1 << sz), 3'd3, 5'h08, 1'b1, 1'b1);
        end
        run("R8 insert signed", rnd128(), d, 4'd2, 3'd1, 5'h08, 1'b0, 1'b1);
        run("R9 bad opcode", rnd128(), d, 4'd4, 3'd1, 5'h04, 1'b1, 1'b1);
        run("R9 64-bit lane narrow", rnd128(), d, 4'd8, 3'd0, 5'h00, 1'b1, 1'b0);
        run("R3 narrow vector", {128{1'b1}}, {128{1'b1}}, 4'd1, 3'd2, 5'h00, 1'b0, 1'b0);
        run("R4 arithmetic negative", {16{8'h80}}, '0, 4'd1, 3'd7, 5'h00, 1'b0, 1'b1);
        run("R4 logical", {16{8'h80}}, rnd128(), 4'd1, 3'd7, 5'h00, 1'b1, 1'b1);
        run("R5 accumulate wrap", {16{8'hFF}}, {16{8'hFF}}, 4'd1, 3'd7, 5'h02, 1'b1, 1'b1);
        for (int k = 0; k < 400; k++) begin
            int sz = int'($urandom_range(0, 3));
            logic [4:0] ops [3] = '{5'h00, 5'h02, 5'h08};
            logic [4:0] op = ops[$urandom_range(0, 2)];
            logic [3:0] h = 4'(1 << sz) | 4'($urandom() & ((1 << sz) - 1));
            if ($urandom_range(0, 19) == 0) op = 5'($urandom());
            run(op == 5'h00 ? "R4 random" : op == 5'h02 ? "R5 random" :
                op == 5'h08 ? "R6 random" : "R9 random",
                rnd128(), rnd128(), h, 3'($urandom()), op, 1'($urandom()),
                (sz == 3) ? ($urandom_range(0, 7) != 0) : 1'($urandom()));
        end
        @(negedge clk);
        check("R10 idle valid", 128'(out_valid), 128'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R10 act=hung exp=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule